// File: doc/BRIEF.md
# SPI FPGA Configuration Sequencer

This block is an SPI master that loads a configuration image into an FPGA that accepts configuration over SPI. A one-cycle `start` pulse launches the load. The block first reads the device identity and checks it against two accepted values. It then prepares and erases the target and polls the target status until the erase completes. It streams the image bytes from a byte-wide ready/valid input inside a single chip-select frame, closes programming and reads the status one last time to judge the outcome.

The interface is simple. The host places the image on `img_data`/`img_valid` with `img_last` on the final byte, and then watches `done` and `err_code`. The width of the SCLK half-period, the poll interval (counted in pulses of an external millisecond tick) and the largest number of polls are parameters. The accepted identity words are also parameters.

Top module: `spi_cfg_loader`

## Requirements
- R1: After reset `spi_cs_n` is 1, `spi_sclk` is 0, and `busy`, `done` and `err_code` are all 0.
- R2: SPI runs in mode 0, most significant bit first. SCLK is low whenever chip select is high. Between two frames chip select stays high for at least two SCLK periods (4·HALF_DIV clocks). Each plain command frame is 4 bytes: the opcode followed by three 0x00 bytes.
- R3: A read frame is 8 bytes: the opcode, three 0x00 bytes, then four 0x00 bytes during which MISO is captured. The captured word is assembled big-endian, so the first received byte becomes bits 31:24.
- R4: The identity (opcode 0x07) must equal ID_A (0xC2088080) or ID_B (0xC2048080). Any other value ends the load with `err_code` 1, and no frame follows the identity read.
- R5: After a valid identity the frames follow in this order: status read 0x09, refresh 0x71, write enable 0x4A, erase 0x70, status polls 0x09, image frame, write disable 0x4F, status read 0x09.
- R6: The erase counts as complete only when a poll returns exactly 0x00010000. A failed poll is followed by the next poll after POLL_MS tick pulses, give or take one.
- R7: If POLL_MAX polls fail, the load ends with `err_code` 2 and no image frame is sent.
- R8: The image frame is 0x41, then 0xFF three times, then every image byte in order, then four 0x00 bytes, all under one chip-select assertion. `img_ready` is high only while no byte is shifting. If `img_valid` drops, SCLK stays low and chip select stays low.
- R9: The load passes (`err_code` 0) when bit 14 (mask 0x00004000) of the final status is set. Otherwise `err_code` is 3.
- R10: If `img_last` is high while `img_valid` is low at the first look after start, the load ends with `err_code` 4 and no SPI frame is sent.
- R11: `done` and `err_code` hold their values until the next `start`, which clears both one cycle later. `err_code` is nonzero only while `done` is high, and `busy` and `done` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin a load, ignored while busy |
| img_data | input | 8 | Image byte |
| img_valid | input | 1 | Image byte is present |
| img_last | input | 1 | Marks the final image byte; alone it marks an empty image |
| img_ready | output | 1 | Image byte is taken on this cycle if valid |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| spi_sclk | output | 1 | SPI clock, idle low |
| spi_mosi | output | 1 | SPI data to the target |
| spi_miso | input | 1 | SPI data from the target |
| spi_cs_n | output | 1 | SPI chip select, active low |
| busy | output | 1 | A load is in progress |
| done | output | 1 | The last load has finished |
| err_code | output | 3 | 0 pass, 1 bad identity, 2 erase timeout, 3 not configured, 4 empty image |

## Verification
Two things can happen in the same cycle: the source withdrawing `img_valid` and the byte engine finishing a byte. If they are not handled together, the frame could be cut or SCLK could keep running. The bench withholds the image byte for longer than a byte time at several points inside the data stream. It then checks that chip select and SCLK stay put and that the frame recorded by the target model matches the expected bytes exactly. The free-running millisecond tick also lands at different phases against the poll gap, and each spacing between polls is held to the allowed window.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;

    localparam logic [7:0] OP_RDID    = 8'h07;
    localparam logic [7:0] OP_RDST    = 8'h09;
    localparam logic [7:0] OP_ERASE   = 8'h70;
    localparam logic [7:0] OP_REFRESH = 8'h71;
    localparam logic [7:0] OP_WREN    = 8'h4A;
    localparam logic [7:0] OP_WRDIS   = 8'h4F;
    localparam logic [7:0] OP_WRINC   = 8'h41;

    localparam logic [31:0] STAT_CLEARED   = 32'h0001_0000;
    localparam logic [31:0] STAT_DONE_MASK = 32'h0000_4000;

    typedef enum logic [2:0] {
        ERR_NONE     = 3'd0,
        ERR_BAD_ID   = 3'd1,
        ERR_TIMEOUT  = 3'd2,
        ERR_NOT_DONE = 3'd3,
        ERR_EMPTY    = 3'd4
    } err_e;

    // Step order is significant: linear steps advance by +1
    typedef enum logic [3:0] {
        SQ_RDID, SQ_RDST_PRE, SQ_REFRESH, SQ_WREN, SQ_ERASE,
        SQ_POLL, SQ_IMAGE, SQ_WRDIS, SQ_RDST_FIN
    } step_e;

    typedef enum logic [2:0] {
        PH_IDLE, PH_PEEK, PH_FRAME, PH_GAP, PH_WAIT
    } phase_e;

endpackage

// File: rtl/cfg_spi_byte.sv
// Shifts one byte out on MOSI and in from MISO in SPI mode 0, MSB first.
// Assumes: go is only raised when the previous byte has finished (done seen).
// SCLK is low for HALF_DIV clocks then high for HALF_DIV clocks per bit.
module cfg_spi_byte #(
    parameter int HALF_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] tx,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       done,
    output logic [7:0] rx
);
    localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic          active;
    logic          hi;
    logic [2:0]    bitc;
    logic [DW-1:0] divc;
    logic [7:0]    sh;

    // Bit timing, shifting and MISO capture on the rising SCLK edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            hi     <= 1'b0;
            bitc   <= '0;
            divc   <= '0;
            sh     <= '0;
            rx     <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!active) begin
                if (go) begin
                    active <= 1'b1;
                    sh     <= tx;
                    bitc   <= '0;
                    divc   <= '0;
                    hi     <= 1'b0;
                end
            end else if (divc == DW'(HALF_DIV - 1)) begin
                divc <= '0;
                if (!hi) begin
                    hi <= 1'b1;
                    rx <= {rx[6:0], miso};
                end else begin
                    hi   <= 1'b0;
                    sh   <= {sh[6:0], 1'b0};
                    bitc <= bitc + 3'd1;
                    if (bitc == 3'd7) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                    end
                end
            end else begin
                divc <= divc + DW'(1);
            end
        end
    end

    assign sclk = hi;
    assign mosi = active & sh[7];

endmodule

// File: rtl/cfg_tick_wait.sv
// Counts external tick pulses while run is high and flags when TICKS have
// been seen. Assumes run drops after expiry; the count clears when run is low.
module cfg_tick_wait #(
    parameter int TICKS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic expired
);
    localparam int CW = $clog2(TICKS + 1);

    logic [CW-1:0] cnt;

    // Tick counter, cleared whenever the wait is not running
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (tick && !expired) begin
            cnt <= cnt + CW'(1);
        end
    end

    assign expired = run && (cnt == CW'(TICKS));

endmodule

// File: rtl/spi_cfg_loader.sv
// Top-level sequencer: identity check, erase with status polling, one-frame
// image stream and a final status judgement over an SPI master.
// Assumes the image source holds img_data/img_last stable while img_valid is
// high, and that ms_tick is a single-cycle pulse.
module spi_cfg_loader
    import cfgseq_pkg::*;
#(
    parameter int          HALF_DIV = 4,
    parameter int          POLL_MS  = 10,
    parameter int          POLL_MAX = 500,
    parameter logic [31:0] ID_A     = 32'hC208_8080,
    parameter logic [31:0] ID_B     = 32'hC204_8080
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] img_data,
    input  logic       img_valid,
    input  logic       img_last,
    output logic       img_ready,
    input  logic       ms_tick,
    output logic       spi_sclk,
    output logic       spi_mosi,
    input  logic       spi_miso,
    output logic       spi_cs_n,
    output logic       busy,
    output logic       done,
    output logic [2:0] err_code
);
    localparam int GAP_CYC = 4 * HALF_DIV;
    localparam int GW      = $clog2(GAP_CYC + 1);
    localparam int PW      = $clog2(POLL_MAX + 1);

    phase_e        ph;
    step_e         step;
    logic [3:0]    idx;
    logic          in_data, tail, inflight;
    logic [31:0]   rword;
    logic [PW-1:0] polls;
    logic [GW-1:0] gapc;
    err_e          err_q;
    logic          done_q;

    logic          is_read, launch, eng_done, tick_exp;
    logic [3:0]    frame_len;
    logic [7:0]    opcode, tx_byte, rx_byte;

    // Frame shape for the current step
    always_comb begin
        is_read   = (step == SQ_RDID) || (step == SQ_RDST_PRE) ||
                    (step == SQ_POLL) || (step == SQ_RDST_FIN);
        frame_len = (is_read || step == SQ_IMAGE) ? 4'd8 : 4'd4;
        case (step)
            SQ_RDID:    opcode = OP_RDID;
            SQ_REFRESH: opcode = OP_REFRESH;
            SQ_WREN:    opcode = OP_WREN;
            SQ_ERASE:   opcode = OP_ERASE;
            SQ_IMAGE:   opcode = OP_WRINC;
            SQ_WRDIS:   opcode = OP_WRDIS;
            default:    opcode = OP_RDST;
        endcase
    end

    // Byte selection and launch condition
    always_comb begin
        if (idx == 4'd0)                          tx_byte = opcode;
        else if (step == SQ_IMAGE && idx < 4'd4)  tx_byte = 8'hFF;
        else if (in_data)                         tx_byte = img_data;
        else                                      tx_byte = 8'h00;
        img_ready = (ph == PH_FRAME) && !inflight && in_data;
        launch    = (ph == PH_FRAME) && !inflight && (!in_data || img_valid);
    end

    cfg_spi_byte #(.HALF_DIV(HALF_DIV)) u_byte (
        .clk(clk), .rst_n(rst_n), .go(launch), .tx(tx_byte), .miso(spi_miso),
        .sclk(spi_sclk), .mosi(spi_mosi), .done(eng_done), .rx(rx_byte)
    );

    cfg_tick_wait #(.TICKS(POLL_MS)) u_wait (
        .clk(clk), .rst_n(rst_n), .run(ph == PH_WAIT), .tick(ms_tick),
        .expired(tick_exp)
    );

    // Sequencer: phases, byte indexing, read capture and step decisions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph <= PH_IDLE;  step <= SQ_RDID;  idx <= '0;
            in_data <= 1'b0;  tail <= 1'b0;  inflight <= 1'b0;
            rword <= '0;  polls <= '0;  gapc <= '0;
            err_q <= ERR_NONE;  done_q <= 1'b0;
        end else begin
            if (launch) begin
                inflight <= 1'b1;
                if (in_data && img_last) tail <= 1'b1;
            end
            case (ph)
                PH_IDLE: if (start) begin
                    done_q <= 1'b0;
                    err_q  <= ERR_NONE;
                    ph     <= PH_PEEK;
                end
                PH_PEEK: if (img_valid) begin
                    step <= SQ_RDID;
                    idx  <= '0;
                    ph   <= PH_FRAME;
                end else if (img_last) begin
                    err_q <= ERR_EMPTY;  done_q <= 1'b1;  ph <= PH_IDLE;
                end
                PH_FRAME: if (eng_done) begin
                    inflight <= 1'b0;
                    if (is_read && idx >= 4'd4) rword <= {rword[23:0], rx_byte};
                    if (in_data) begin
                        if (tail) begin
                            in_data <= 1'b0;
                            tail    <= 1'b0;
                        end
                    end else if (idx == frame_len - 4'd1) begin
                        idx  <= '0;
                        gapc <= '0;
                        ph   <= PH_GAP;
                    end else begin
                        idx <= idx + 4'd1;
                        if (step == SQ_IMAGE && idx == 4'd3) in_data <= 1'b1;
                    end
                end
                PH_GAP: if (gapc == GW'(GAP_CYC - 1)) begin
                    ph <= PH_FRAME;
                    case (step)
                        SQ_RDID: if (rword == ID_A || rword == ID_B) begin
                            step <= SQ_RDST_PRE;
                        end else begin
                            err_q <= ERR_BAD_ID;  done_q <= 1'b1;  ph <= PH_IDLE;
                        end
                        SQ_ERASE: begin
                            step  <= SQ_POLL;
                            polls <= '0;
                        end
                        SQ_POLL: if (rword == STAT_CLEARED) begin
                            step <= SQ_IMAGE;
                        end else if (polls == PW'(POLL_MAX - 1)) begin
                            err_q <= ERR_TIMEOUT;  done_q <= 1'b1;  ph <= PH_IDLE;
                        end else begin
                            polls <= polls + PW'(1);
                            ph    <= PH_WAIT;
                        end
                        SQ_RDST_FIN: begin
                            err_q  <= ((rword & STAT_DONE_MASK) != 32'd0) ? ERR_NONE
                                                                          : ERR_NOT_DONE;
                            done_q <= 1'b1;
                            ph     <= PH_IDLE;
                        end
                        default: step <= step_e'(step + 4'd1);
                    endcase
                end else begin
                    gapc <= gapc + GW'(1);
                end
                PH_WAIT: if (tick_exp) ph <= PH_FRAME;
                default: ph <= PH_IDLE;
            endcase
        end
    end

    assign spi_cs_n = (ph != PH_FRAME);
    assign busy     = (ph != PH_IDLE);
    assign done     = done_q;
    assign err_code = err_q;

endmodule

// File: rtl/spi_cfg_loader_chk.sv
// Protocol and result-holding properties for spi_cfg_loader, attached by bind.
// Assumes synchronous active-low reset; every property is disabled in reset.
module spi_cfg_loader_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       img_ready,
    input logic       spi_sclk,
    input logic       spi_cs_n,
    input logic       busy,
    input logic       done,
    input logic [2:0] err_code
);
    // R2
    sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);

    // R8
    ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        img_ready |-> (!spi_sclk && !spi_cs_n));

    // R10
    cs_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> spi_cs_n);

    // R11
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(err_code)));

    // R11
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_code != 3'd0) |-> done);

    // R11
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

endmodule

bind spi_cfg_loader spi_cfg_loader_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .img_ready(img_ready),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .busy(busy), .done(done),
    .err_code(err_code)
);

// File: tb/spi_cfg_loader_tb.sv
module spi_cfg_loader_tb;
    localparam int HALF   = 2;
    localparam int PMS    = 3;
    localparam int PMAX   = 4;
    localparam int TICK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] img_data = 8'h00;
    logic       img_valid = 1'b0;
    logic       img_last = 1'b0;
    logic       img_ready;
    logic       ms_tick = 1'b0;
    logic       spi_sclk, spi_mosi, spi_miso, spi_cs_n;
    logic       busy, done;
    logic [2:0] err_code;

    always #10 clk = ~clk;

    spi_cfg_loader #(.HALF_DIV(HALF), .POLL_MS(PMS), .POLL_MAX(PMAX)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .img_data(img_data),
        .img_valid(img_valid), .img_last(img_last), .img_ready(img_ready),
        .ms_tick(ms_tick), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .spi_cs_n(spi_cs_n), .busy(busy), .done(done),
        .err_code(err_code)
    );

    int errs = 0;
    int checks = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // ---------------- target model ----------------
    int          bits = 0;
    logic [7:0]  cur = 8'h00;
    logic [7:0]  op_seen = 8'h00;
    byte unsigned fr_q[$];
    logic [31:0] id_val = 32'h0;
    logic [31:0] st_final = 32'h0;
    int          clear_after = 0;
    int          polls_seen = 0;
    bit          erase_seen = 0;
    bit          image_seen = 0;
    logic [31:0] cur_status, resp_word;

    always @* begin
        if (image_seen)          cur_status = st_final;
        else if (!erase_seen)    cur_status = 32'h0000_0000;
        else if (polls_seen == 0 && clear_after > 0) cur_status = 32'h0001_0001;
        else if (polls_seen < clear_after)           cur_status = 32'h0000_0000;
        else                                         cur_status = 32'h0001_0000;
        if (op_seen == 8'h07)      resp_word = id_val;
        else if (op_seen == 8'h09) resp_word = cur_status;
        else                       resp_word = 32'h0;
    end

    assign spi_miso = (bits >= 32 && bits < 64) ? resp_word[63 - bits] : 1'b0;

    always @(posedge spi_sclk) if (!spi_cs_n) begin
        cur = {cur[6:0], spi_mosi};
        bits++;
        if (bits % 8 == 0) begin
            fr_q.push_back(cur);
            if (bits == 8) op_seen = cur;
        end
    end

    // ---------------- scoreboard ----------------
    int          exp_len[$];
    byte unsigned exp_b[$];
    int          frames_seen = 0;
    longint      cyc = 0;
    longint      ticks = 0;
    longint      c_rise = 0;
    longint      t_rise = 0;
    bit          tracking = 0;

    always @(posedge clk) begin
        cyc++;
        if (ms_tick) ticks++;
    end

    always @(negedge spi_cs_n) begin
        if (frames_seen > 0)
            chk(cyc - c_rise >= 4 * HALF, "R2 cs gap", 32'(cyc - c_rise), 32'(4 * HALF));
        if (tracking) begin
            chk((ticks - t_rise) >= PMS && (ticks - t_rise) <= PMS + 1,
                "R6 poll spacing", 32'(ticks - t_rise), 32'(PMS));
            tracking = 0;
        end
        bits = 0;
        op_seen = 8'h00;
        fr_q.delete();
    end

    always @(posedge spi_cs_n) begin
        int n;
        bit ok;
        frames_seen++;
        c_rise = cyc;
        if (op_seen == 8'h09 && erase_seen && !image_seen) begin
            tracking = (cur_status != 32'h0001_0000);
            t_rise = ticks;
            polls_seen++;
        end
        if (op_seen == 8'h70) erase_seen = 1;
        if (op_seen == 8'h41) image_seen = 1;
        if (exp_len.size() == 0) begin
            chk(0, "R5 unexpected frame", 32'(op_seen), 32'h0);
        end else begin
            n = exp_len.pop_front();
            ok = (fr_q.size() == n);
            for (int i = 0; i < n; i++) begin
                byte unsigned e;
                e = exp_b.pop_front();
                if (i < fr_q.size() && fr_q[i] != e) ok = 0;
            end
            chk(ok, "R5/R8 frame bytes (R2 R3 shape)", 32'(fr_q.size()), 32'(n));
        end
    end

    task automatic push_cmd(input byte unsigned op, input bit rd);
        exp_len.push_back(rd ? 8 : 4);
        exp_b.push_back(op);
        for (int i = 0; i < (rd ? 7 : 3); i++) exp_b.push_back(8'h00);
    endtask

    byte unsigned img_mem[16];

    task automatic push_image(input int n);
        exp_len.push_back(n + 8);
        exp_b.push_back(8'h41);
        for (int i = 0; i < 3; i++) exp_b.push_back(8'hFF);
        for (int i = 0; i < n; i++) exp_b.push_back(img_mem[i]);
        for (int i = 0; i < 4; i++) exp_b.push_back(8'h00);
    endtask

    // ---------------- drivers ----------------
    initial begin
        forever begin
            repeat (TICK_P - 1) @(negedge clk);
            ms_tick = 1'b1;
            @(negedge clk);
            ms_tick = 1'b0;
        end
    end

    task automatic drive_img(input int n, input int stall_every);
        bit acc, hit;
        for (int i = 0; i < n; i++) begin
            img_data = img_mem[i];
            img_valid = 1'b1;
            img_last = (i == n - 1);
            acc = 0;
            while (!acc && !done) begin
                hit = img_ready;
                @(posedge clk);
                acc = hit;
                @(negedge clk);
            end
            img_valid = 1'b0;
            img_last = 1'b0;
            if (!acc) break;
            if (stall_every != 0 && i % stall_every == 1 && i != n - 1) begin
                repeat (40) @(negedge clk);
                chk(!spi_cs_n && !spi_sclk, "R8 stall holds frame",
                    {30'd0, spi_cs_n, spi_sclk}, 32'd0);
            end
        end
    endtask

    task automatic new_run(input logic [31:0] id, input int clr, input logic [31:0] fin);
        id_val = id;  clear_after = clr;  st_final = fin;
        polls_seen = 0;  erase_seen = 0;  image_seen = 0;
        frames_seen = 0;  tracking = 0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(done == 1'b0 && err_code == 3'd0, "R11 start clears result",
            {29'd0, err_code}, 32'd0);
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic final_report();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog", 32'(cyc), 32'd0);
        final_report();
    end

    initial begin
        for (int i = 0; i < 16; i++) img_mem[i] = byte'(8'h3C ^ (i * 8'h17));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(spi_cs_n == 1'b1, "R1 cs_n", {31'd0, spi_cs_n}, 32'd1);
        chk(spi_sclk == 1'b0, "R1 sclk", {31'd0, spi_sclk}, 32'd0);
        chk(!busy && !done, "R1 busy/done", {30'd0, busy, done}, 32'd0);
        chk(err_code == 3'd0, "R1 err", {29'd0, err_code}, 32'd0);

        // R10 empty image
        new_run(32'hC208_8080, 0, 0);
        img_last = 1'b1;
        pulse_start();
        wait_done();
        img_last = 1'b0;
        chk(err_code == 3'd4, "R10 empty err", {29'd0, err_code}, 32'd4);
        chk(frames_seen == 0, "R10 no traffic", 32'(frames_seen), 32'd0);
        repeat (30) @(negedge clk);
        chk(done && err_code == 3'd4, "R11 result held", {29'd0, err_code}, 32'd4);

        // R4 unsupported identity
        new_run(32'h1234_5678, 0, 0);
        push_cmd(8'h07, 1);
        pulse_start();
        fork drive_img(1, 0); join_none
        wait_done();
        chk(err_code == 3'd1, "R4 bad id err", {29'd0, err_code}, 32'd1);
        chk(exp_len.size() == 0 && frames_seen == 1, "R4 only id frame",
            32'(frames_seen), 32'd1);
        repeat (5) @(negedge clk);

        // R5 R6 R8 R9 R3 successful load with stalls
        new_run(32'hC208_8080, 2, 32'h0001_4000);
        push_cmd(8'h07, 1); push_cmd(8'h09, 1); push_cmd(8'h71, 0);
        push_cmd(8'h4A, 0); push_cmd(8'h70, 0);
        for (int i = 0; i < 3; i++) push_cmd(8'h09, 1);
        push_image(6);
        push_cmd(8'h4F, 0); push_cmd(8'h09, 1);
        pulse_start();
        fork drive_img(6, 2); join_none
        wait_done();
        chk(err_code == 3'd0, "R9 pass (R3 id accepted)", {29'd0, err_code}, 32'd0);
        chk(exp_len.size() == 0, "R5 all frames seen", 32'(exp_len.size()), 32'd0);
        chk(polls_seen == 3, "R6 exact clear match", 32'(polls_seen), 32'd3);
        repeat (5) @(negedge clk);

        // R7 erase timeout
        new_run(32'hC204_8080, 100, 32'h0);
        push_cmd(8'h07, 1); push_cmd(8'h09, 1); push_cmd(8'h71, 0);
        push_cmd(8'h4A, 0); push_cmd(8'h70, 0);
        for (int i = 0; i < PMAX; i++) push_cmd(8'h09, 1);
        pulse_start();
        fork drive_img(2, 0); join_none
        wait_done();
        chk(err_code == 3'd2, "R7 timeout err", {29'd0, err_code}, 32'd2);
        chk(exp_len.size() == 0 && !image_seen, "R7 no image frame",
            32'(exp_len.size()), 32'd0);
        repeat (5) @(negedge clk);

        // R9 done bit missing, one-byte image
        new_run(32'hC204_8080, 1, 32'h0001_0000);
        push_cmd(8'h07, 1); push_cmd(8'h09, 1); push_cmd(8'h71, 0);
        push_cmd(8'h4A, 0); push_cmd(8'h70, 0);
        push_cmd(8'h09, 1); push_cmd(8'h09, 1);
        push_image(1);
        push_cmd(8'h4F, 0); push_cmd(8'h09, 1);
        pulse_start();
        fork drive_img(1, 0); join_none
        wait_done();
        chk(err_code == 3'd3, "R9 not configured err", {29'd0, err_code}, 32'd3);
        chk(exp_len.size() == 0, "R5 R8 single byte frame", 32'(exp_len.size()), 32'd0);

        final_report();
    end

endmodule